// File: doc/BRIEF.md
# Dual-Style Host Register Interface

This block is the host-side register file of a programmable FIR filter. An 8-bit bus with a 2-bit address and an active-low select reaches four locations: a write-only coefficient port, a configuration register, a normalization/rounding register and a filter-order register. Bus strobes are sampled on the system clock. The block can decode them in two ways. In Motorola style, one data strobe is qualified by a read/write line. In Intel style, there are separate write and read strobes. The style is picked by a configuration bit that only takes effect once the lock bit is set. Until then, and after every reset, the interface decodes Motorola style.

The coefficient port accepts a stream of bytes. Each pair of bytes becomes one 16-bit coefficient, and a configuration bit chooses whether the high or the low byte comes first. Each finished coefficient leaves the block as a one-cycle write strobe, together with an index from an internal pointer. The pointer wraps after the last tap. Writing the filter-order register restarts the stream. The configuration register also shows two status flags derived from the pointer, plus a buffer-full flag supplied by the datapath.

Top module: `host_regif`

## Requirements
- R1: After reset, all writable configuration bits are 0, the normalization and order registers are 0, and coef_we_o is low. A configuration read returns 0xC0 while buf_full_i is low.
- R2: Motorola style is in force whenever the lock bit (configuration bit 3) is clear. In this style, a write is strb_a_ni low with strb_b_ni low, and a read is strb_a_ni low with strb_b_ni high. A strobe pattern of strb_a_ni low with strb_b_ni high therefore never writes.
- R3: With the lock bit and bit 1 both set, Intel style applies. A write is strb_a_ni low. A read is strb_b_ni low while strb_a_ni is high. Writes take effect once per falling strobe.
- R4: While the lock bit is set, a configuration write that keeps bit 3 set leaves bit 1 unchanged. A write that clears bit 3 returns the bus to Motorola style.
- R5: While the lock bit is clear, writes to addresses 0, 2 and 3 are ignored.
- R6: Reads return the following, and rdata_o is 0 whenever no read is active:
  - address 1: {last-coefficient flag, last-group flag, buf_full_i, bits 4:0}
  - address 2: {3'b0, normalization bits 4:0}
  - address 3: the order register
  - address 0: 0
- R7: Normalization bits 3:0 drive norm_sel_o and bit 4 drives round_en_o. Data bits 7:5 are dropped on write.
- R8: Every second byte written to address 0 produces a one-cycle coef_we_o pulse in the cycle after that write. With configuration bit 2 set, the first byte is the high byte of coef_data_o; otherwise the first byte is the low byte.
- R9: coef_addr_o starts at 0 and advances by one per coefficient. After the coefficient at index order_o it returns to 0, where order_o is the tap count minus 1.
- R10: A write to address 3 clears the coefficient pointer and discards a pending first byte.
- R11: While configuration bit 0 (run) is set, byte writes to address 0 are ignored and leave the pointer unchanged.
- R12: Configuration read bit 7 is 1 when the pointer equals order_o. Bit 6 is 1 when pointer/4 equals order_o/4.
- R13: run_o follows configuration bit 0 and seq_mode_o follows bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| cs_ni | input | 1 | Chip select, active low |
| strb_a_ni | input | 1 | Data strobe (Motorola) or write strobe (Intel), active low |
| strb_b_ni | input | 1 | Read/write line, high = read (Motorola), or read strobe (Intel), active low |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no read is active |
| buf_full_i | input | 1 | Sample buffer full flag from the datapath |
| run_o | output | 1 | Filter running |
| seq_mode_o | output | 1 | Sequential (1) or single (0) cell mode |
| round_en_o | output | 1 | Rounding enable |
| norm_sel_o | output | 4 | Output bit-window select |
| order_o | output | 8 | Tap count minus 1 |
| coef_we_o | output | 1 | Coefficient write strobe, one cycle |
| coef_addr_o | output | 8 | Coefficient index |
| coef_data_o | output | 16 | Assembled coefficient |

## Verification
The bench uses the default build: 8-bit bytes, a 256-entry coefficient space and groups of 4 taps. Under that build the 8-bit order register covers the whole pointer range. The bench sweeps both bus styles, both byte orders and tap counts 1 to 9. That sweep crosses the pointer wrap and the last-group boundary at 4 and 8 taps. The expected coefficient values and status flags are computed arithmetically from the tap index. Separate sequences cover the lock-held style bit, unlocked writes, writes while running, and a restart in the middle of a coefficient.

// File: rtl/host_regif_pkg.sv
package host_regif_pkg;
  typedef enum logic [1:0] {
    A_COEF  = 2'd0,
    A_CFG   = 2'd1,
    A_NORM  = 2'd2,
    A_ORDER = 2'd3
  } hr_addr_e;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_INTEL = 1;
  localparam int unsigned CB_MSBF  = 2;
  localparam int unsigned CB_LOCK  = 3;
  localparam int unsigned CB_SEQ   = 4;
  localparam int unsigned CFG_W    = 5;
endpackage

// File: rtl/hr_bus_decode.sv
module hr_bus_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intel_i,
  input  logic cs_ni,
  input  logic strb_a_ni,
  input  logic strb_b_ni,
  output logic wr_pulse_o,
  output logic rd_act_o
);
  logic wr_act, wr_q;

  always_comb begin
    if (intel_i) begin
      wr_act   = !cs_ni && !strb_a_ni;
      rd_act_o = !cs_ni && !strb_b_ni && strb_a_ni;
    end else begin
      wr_act   = !cs_ni && !strb_a_ni && !strb_b_ni;
      rd_act_o = !cs_ni && !strb_a_ni && strb_b_ni;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_act;

  // one write per strobe assertion
  assign wr_pulse_o = wr_act && !wr_q;

  // R2
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o);
endmodule

// File: rtl/hr_coef_seq.sv
module hr_coef_seq #(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned GRP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            byte_we_i,
  input  logic            msb_first_i,
  input  logic [DW-1:0]   byte_i,
  input  logic [AW-1:0]   last_idx_i,
  output logic            coef_we_o,
  output logic [AW-1:0]   coef_addr_o,
  output logic [2*DW-1:0] coef_data_o,
  output logic            last_grp_o,
  output logic            last_coef_o
);
  localparam int unsigned GW = $clog2(GRP);

  logic          half_q;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q      <= 1'b0;
      hold_q      <= '0;
      ptr_q       <= '0;
      coef_we_o   <= 1'b0;
      coef_addr_o <= '0;
      coef_data_o <= '0;
    end else begin
      coef_we_o <= 1'b0;
      if (clr_i) begin
        half_q <= 1'b0;
        ptr_q  <= '0;
      end else if (byte_we_i) begin
        if (!half_q) begin
          hold_q <= byte_i;
          half_q <= 1'b1;
        end else begin
          half_q      <= 1'b0;
          coef_we_o   <= 1'b1;
          coef_addr_o <= ptr_q;
          coef_data_o <= msb_first_i ? {hold_q, byte_i} : {byte_i, hold_q};
          ptr_q       <= (ptr_q == last_idx_i) ? '0 : ptr_q + 1'b1;
        end
      end
    end
  end

  assign last_coef_o = (ptr_q == last_idx_i);
  assign last_grp_o  = ((ptr_q >> GW) == (last_idx_i >> GW));

  // R8
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |=> !coef_we_o);
  // R9
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> coef_addr_o <= last_idx_i);
  // R10
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0) && !half_q && !coef_we_o);
endmodule

// File: rtl/host_regif.sv
module host_regif
  import host_regif_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned NTAP_MAX = 256,
  parameter int unsigned GRP      = 4,
  parameter int unsigned NSEL     = 4,
  localparam int unsigned AW      = $clog2(NTAP_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            strb_a_ni,
  input  logic            strb_b_ni,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            buf_full_i,
  output logic            run_o,
  output logic            seq_mode_o,
  output logic            round_en_o,
  output logic [NSEL-1:0] norm_sel_o,
  output logic [AW-1:0]   order_o,
  output logic            coef_we_o,
  output logic [AW-1:0]   coef_addr_o,
  output logic [2*DW-1:0] coef_data_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [NSEL:0]    norm_q;
  logic [AW-1:0]    order_q;
  logic             locked, intel_eff;
  logic             wr_pulse, rd_act;
  logic             wr_cfg, wr_norm, wr_order, wr_coef;
  logic             last_grp, last_coef;

  assign locked    = cfg_q[CB_LOCK];
  assign intel_eff = locked && cfg_q[CB_INTEL];

  hr_bus_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .intel_i    (intel_eff),
    .cs_ni      (cs_ni),
    .strb_a_ni  (strb_a_ni),
    .strb_b_ni  (strb_b_ni),
    .wr_pulse_o (wr_pulse),
    .rd_act_o   (rd_act)
  );

  assign wr_cfg   = wr_pulse && (addr_i == A_CFG);
  assign wr_norm  = wr_pulse && (addr_i == A_NORM)  && locked;
  assign wr_order = wr_pulse && (addr_i == A_ORDER) && locked;
  assign wr_coef  = wr_pulse && (addr_i == A_COEF)  && locked && !cfg_q[CB_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      norm_q  <= '0;
      order_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q[CB_RUN]  <= wdata_i[CB_RUN];
        cfg_q[CB_MSBF] <= wdata_i[CB_MSBF];
        cfg_q[CB_LOCK] <= wdata_i[CB_LOCK];
        cfg_q[CB_SEQ]  <= wdata_i[CB_SEQ];
        // style frozen while the lock stays set
        if (!locked || !wdata_i[CB_LOCK]) cfg_q[CB_INTEL] <= wdata_i[CB_INTEL];
      end
      if (wr_norm)  norm_q  <= wdata_i[NSEL:0];
      if (wr_order) order_q <= AW'(wdata_i);
    end
  end

  hr_coef_seq #(.DW(DW), .AW(AW), .GRP(GRP)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (wr_order),
    .byte_we_i   (wr_coef),
    .msb_first_i (cfg_q[CB_MSBF]),
    .byte_i      (wdata_i),
    .last_idx_i  (order_q),
    .coef_we_o   (coef_we_o),
    .coef_addr_o (coef_addr_o),
    .coef_data_o (coef_data_o),
    .last_grp_o  (last_grp),
    .last_coef_o (last_coef)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      unique case (addr_i)
        A_CFG:   rdata_o = DW'({last_coef, last_grp, buf_full_i, cfg_q});
        A_NORM:  rdata_o = DW'(norm_q);
        A_ORDER: rdata_o = DW'(order_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign run_o      = cfg_q[CB_RUN];
  assign seq_mode_o = cfg_q[CB_SEQ];
  assign round_en_o = norm_q[NSEL];
  assign norm_sel_o = norm_q[NSEL-1:0];
  assign order_o    = order_q;

  // R4
  style_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $past(locked)) |-> $stable(cfg_q[CB_INTEL]));
  // R11
  run_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_o |-> !$past(cfg_q[CB_RUN]));
  // R5
  unlocked_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(locked) |-> $stable(order_q));
endmodule

// File: tb/host_regif_bench.sv
module host_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sa_n = 1'b1, sb_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        buf_full = 1'b0;
  logic        run, seqm, rnd;
  logic [3:0]  nsel;
  logic [7:0]  order;
  logic        cwe;
  logic [7:0]  caddr;
  logic [15:0] cdata;

  int checks = 0, errors = 0;
  bit intel = 0;

  always #5 clk = ~clk;

  host_regif u_host_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .strb_a_ni(sa_n), .strb_b_ni(sb_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .buf_full_i(buf_full),
    .run_o(run), .seq_mode_o(seqm), .round_en_o(rnd), .norm_sel_o(nsel),
    .order_o(order), .coef_we_o(cwe), .coef_addr_o(caddr), .coef_data_o(cdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // raw strobe cycle: one clock low, released at the following negedge
  task automatic strobe(input logic [1:0] a, input logic [7:0] d, input logic a_n, input logic b_n);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d; sa_n = a_n; sb_n = b_n;
    @(negedge clk);
    cs_n = 1'b1; sa_n = 1'b1; sb_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    if (intel) strobe(a, d, 1'b0, 1'b1);
    else       strobe(a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a;
    if (intel) begin sa_n = 1'b1; sb_n = 1'b0; end
    else       begin sa_n = 1'b0; sb_n = 1'b1; end
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; sa_n = 1'b1; sb_n = 1'b1;
  endtask

  function automatic logic [7:0] stat(input int ptr, input int ordv);
    return {(ptr == ordv) ? 1'b1 : 1'b0, ((ptr / 4) == (ordv / 4)) ? 1'b1 : 1'b0, 6'b0};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 run", run, 0); chk("R1 cwe", cwe, 0); chk("R1 order", order, 0);
    rd(2'd1, d); chk("R1 cfg", d, 8'hC0);
    rd(2'd2, d); chk("R1 norm", d, 8'h00);
    // R6 idle data bus
    #1 chk("R6 idle bus", rdata, 0);

    // R5 unlocked writes ignored
    wr(2'd3, 8'h05); rd(2'd3, d); chk("R5 order unlocked", d, 8'h00);
    wr(2'd2, 8'h1F); rd(2'd2, d); chk("R5 norm unlocked", d, 8'h00);
    // R2 Intel-style write pattern is a Motorola read: no write
    strobe(2'd1, 8'h1B, 1'b0, 1'b1);
    rd(2'd1, d); chk("R2 no write", d, 8'hC0);
    // R2 Intel read pattern ignored before lock
    @(negedge clk); cs_n = 0; addr = 2'd1; sa_n = 1; sb_n = 0;
    #1 chk("R2 no read", rdata, 0);
    @(negedge clk); cs_n = 1; sb_n = 1;

    // R8 R9 R12 sweep over style, byte order, tap count
    for (int st = 0; st < 2; st++) begin
      for (int mf = 0; mf < 2; mf++) begin
        for (int nt = 1; nt <= 9; nt++) begin
          logic [7:0] cfgv;
          cfgv = 8'h08 | (st ? 8'h02 : 8'h00) | (mf ? 8'h04 : 8'h00);
          wr(2'd1, 8'h00); intel = 0;
          wr(2'd1, cfgv);  intel = (st != 0);
          wr(2'd3, 8'(nt - 1));
          rd(2'd3, d); chk("R6 order read", d, 8'(nt - 1));
          rd(2'd1, d); chk("R12 status start", d, stat(0, nt - 1) | cfgv);
          for (int k = 0; k < nt; k++) begin
            logic [15:0] c;
            c = 16'((k + 1) * 16'h1357 + st * 16'h0101 + mf * 16'h2002 + nt);
            wr(2'd0, mf ? c[15:8] : c[7:0]);
            chk("R8 no strobe first byte", cwe, 0);
            wr(2'd0, mf ? c[7:0] : c[15:8]);
            chk("R8 strobe", cwe, 1);
            chk("R8 data", cdata, c);
            chk("R9 addr", caddr, 8'(k));
            @(negedge clk);
            chk("R8 one cycle", cwe, 0);
            rd(2'd1, d);
            chk("R12 status", d, stat((k == nt - 1) ? 0 : k + 1, nt - 1) | cfgv);
          end
        end
      end
    end

    // R3 Intel locked: check read values and style
    rd(2'd1, d); chk("R3 intel cfg", d[3:0], 4'hE);
    // R4 lock held: write with bit1 clear keeps Intel style
    wr(2'd1, 8'h08);
    rd(2'd1, d); chk("R4 style kept", d[3:0], 4'hA);

    // R7 normalization
    wr(2'd2, 8'h1F); rd(2'd2, d); chk("R7 norm read", d, 8'h1F);
    chk("R7 round", rnd, 1); chk("R7 sel", nsel, 4'hF);
    wr(2'd2, 8'hE5); rd(2'd2, d); chk("R7 high bits drop", d, 8'h05);
    chk("R7 round off", rnd, 0); chk("R7 sel 5", nsel, 4'h5);

    // R6 address 0 and buffer full flag
    rd(2'd0, d); chk("R6 coef port read", d, 0);
    buf_full = 1'b1;
    rd(2'd1, d); chk("R6 buf full", d[5], 1);
    buf_full = 1'b0;

    // R13 run and mode outputs, R11 writes ignored while running
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h19);
    chk("R13 run", run, 1); chk("R13 seq", seqm, 1);
    wr(2'd0, 8'hAA); chk("R11 no strobe", cwe, 0);
    wr(2'd0, 8'hBB); chk("R11 no strobe 2", cwe, 0);
    rd(2'd1, d); chk("R11 ptr unchanged", d[7:6], 2'b01);
    wr(2'd1, 8'h08);
    chk("R13 stop", run, 0); chk("R13 single", seqm, 0);
    wr(2'd0, 8'h34); wr(2'd0, 8'h12);
    chk("R11 resumed strobe", cwe, 1); chk("R11 addr", caddr, 0);
    chk("R11 data lsb first", cdata, 16'h1234);

    // R10 order write discards pending byte and pointer
    wr(2'd0, 8'h77);
    wr(2'd3, 8'h02);
    wr(2'd0, 8'hCD); chk("R10 pending dropped", cwe, 0);
    wr(2'd0, 8'hAB);
    chk("R10 strobe", cwe, 1); chk("R10 addr", caddr, 0);
    chk("R10 data", cdata, 16'hABCD);

    // R4 clearing lock returns to Motorola style
    wr(2'd1, 8'h00); intel = 0;
    rd(2'd1, d); chk("R4 unlocked moto read", d[3:0], 4'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule